// File: doc/BRIEF.md
# Debounced Button Press Counter

This block counts presses of a mechanical push button and shows the running total in binary on a pair of LED outputs. The raw button line arrives with no timing relation to the clock and bounces on every press and release. Two flip-flops bring it into the clock domain. A stability filter then accepts a new button level only once the input has held that level for a set number of consecutive clocks.

A rising-edge detector on the filtered level makes one single-cycle pulse per press, and that pulse steps a small counter that wraps from its top value back to zero. The reset input is also asynchronous. It is brought into the clock domain through its own two-flop chain, and the synchronized reset then clears the counter synchronously, ahead of any increment in the same clocked process.

While reset is active, the filter and the edge history take on the current synchronized button level. A button held down through the end of reset therefore does not register as a press. The block is meant to sit directly between a board button and a set of LEDs.

Top module: `btn_press_counter`

## Requirements
- R1: With the button line stable and the filter at rest, a rising change on `btn_in` applied between clock edges reaches `led_count` on the (DEB_CYCLES + 3)-th rising edge after the change: two synchronizer edges, DEB_CYCLES filter edges, and one counter edge. The count is unchanged after (DEB_CYCLES + 2) edges.
- R2: Holding the button down for any length of time adds exactly one to the count, and the internal press pulse is never high on two consecutive cycles.
- R3: Each accepted press adds one to the COUNT_W-bit count, modulo 2^COUNT_W. With the default COUNT_W = 2, the count goes 0, 1, 2, 3 and then wraps to 0.
- R4: A button level that lasts fewer than DEB_CYCLES consecutive synchronized clocks is ignored, both as a glitch on the idle line and as bounce around a press or a release. A bounced press adds exactly one.
- R5: Reset acts synchronously through a two-flop synchronizer. A high `rst_in` applied between edges leaves the count unchanged after two rising edges and makes it zero after the third. Reset takes priority over an increment.
- R6: If the button is held while reset is released, no increment follows. The next increment needs a release and a new press.
- R7: `led_count` presents the count in plain binary, and it reads 0 after reset with the button released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Reset, active high, asynchronous to clk |
| btn_in | input | 1 | Raw button level, active high, asynchronous to clk, may bounce |
| led_count | output | COUNT_W | Press count in binary |

## Verification
On every cycle, the assertions check four things: a synchronized reset empties the count on the next edge; the count moves only by one and only on a press pulse; the press pulse never lasts two cycles; and the filtered level only ever moves to the value the synchronizer held. The exact latency from the button to the LEDs, the rejection of bounce shorter than the filter window, the wrap after many presses, and the case of a button held through reset all depend on input history over many cycles. Only the bench's timed scenarios can show these.

// File: rtl/btn_press_counter.sv
module btn_press_counter #(
  parameter int COUNT_W    = 2,
  parameter int DEB_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_in,
  input  logic               btn_in,
  output logic [COUNT_W-1:0] led_count
);
  localparam int DW = $clog2(DEB_CYCLES + 1);

  logic          rst_m, rst_q;
  logic          btn_m, btn_s;
  logic [DW-1:0] stab_q;
  logic          deb_level, hist_q, press_pulse;
  logic [COUNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    rst_m <= rst_in;
    rst_q <= rst_m;
    btn_m <= btn_in;
    btn_s <= btn_m;
  end

  always_ff @(posedge clk) begin
    if (rst_q) begin
      deb_level <= btn_s;
      stab_q    <= '0;
    end else if (btn_s == deb_level) begin
      stab_q    <= '0;
    end else if (stab_q == DW'(DEB_CYCLES - 1)) begin
      deb_level <= btn_s;
      stab_q    <= '0;
    end else begin
      stab_q    <= stab_q + DW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_q) hist_q <= btn_s;
    else       hist_q <= deb_level;
  end

  assign press_pulse = deb_level & ~hist_q;

  always_ff @(posedge clk) begin
    if (rst_q)            count_q <= '0;
    else if (press_pulse) count_q <= count_q + COUNT_W'(1);
  end

  assign led_count = count_q;
endmodule

module btn_press_counter_chk #(
  parameter int COUNT_W = 2
) (
  input logic               clk,
  input logic               rst_q,
  input logic               btn_s,
  input logic               deb_level,
  input logic               press_pulse,
  input logic [COUNT_W-1:0] count
);
  p_reset_clears_r5: assert property (@(posedge clk) rst_q |=> count == '0);

  p_step_one_r3: assert property (@(posedge clk) disable iff (rst_q)
    press_pulse |=> count == $past(count) + COUNT_W'(1));

  p_hold_still_r2: assert property (@(posedge clk) disable iff (rst_q)
    !press_pulse |=> $stable(count));

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst_q)
    press_pulse |=> !press_pulse);

  p_filter_follows_sync_r4: assert property (@(posedge clk) disable iff (rst_q)
    (deb_level != $past(deb_level)) |-> deb_level == $past(btn_s));
endmodule

bind btn_press_counter btn_press_counter_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rst_q(rst_q), .btn_s(btn_s), .deb_level(deb_level),
  .press_pulse(press_pulse), .count(led_count)
);

// File: tb/btn_press_counter_tb.sv
module btn_press_counter_tb;
  localparam int COUNT_W    = 2;
  localparam int DEB_CYCLES = 4;
  localparam int MODV       = 1 << COUNT_W;

  logic clk = 1'b0;
  logic rst_in = 1'b1;
  logic btn_in = 1'b0;
  logic [COUNT_W-1:0] led_count;

  int checks = 0;
  int errors = 0;
  int expv   = 0;

  btn_press_counter #(.COUNT_W(COUNT_W), .DEB_CYCLES(DEB_CYCLES)) u_dut (
    .clk(clk), .rst_in(rst_in), .btn_in(btn_in), .led_count(led_count)
  );

  always #5 clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int exp);
    checks++;
    if (int'(led_count) != exp) begin
      errors++;
      $display("FAIL %s: led_count=%0d expected %0d", tag, led_count, exp);
    end
  endtask

  task automatic clean_press();
    btn_in = 1'b1; cyc(DEB_CYCLES + 8);
    btn_in = 1'b0; cyc(DEB_CYCLES + 8);
    expv = (expv + 1) % MODV;
  endtask

  initial begin
    cyc(6);
    rst_in = 1'b0;
    cyc(3);
    check("R7 reset value", 0);

    // R1 exact latency
    btn_in = 1'b1;
    cyc(DEB_CYCLES + 2);
    check("R1 not yet", 0);
    cyc(1);
    check("R1 arrival", 1);
    expv = 1;
    // R2 long hold
    cyc(60);
    check("R2 held press", expv);
    btn_in = 1'b0; cyc(20);
    check("R2 after release", expv);

    // R3 sweep through several wraps
    for (int i = 0; i < 3 * MODV; i++) begin
      clean_press();
      check("R3 count sweep", expv);
    end

    // R4 idle glitches of every short width
    for (int w = 1; w < DEB_CYCLES; w++) begin
      btn_in = 1'b1; cyc(w);
      btn_in = 1'b0; cyc(DEB_CYCLES + 8);
      check("R4 glitch ignored", expv);
    end

    // R4 bounced press and bounced release
    for (int w = 1; w < DEB_CYCLES; w++) begin
      btn_in = 1'b1; cyc(w);
      btn_in = 1'b0; cyc(1);
      btn_in = 1'b1; cyc(1);
      btn_in = 1'b0; cyc(w);
      btn_in = 1'b1; cyc(DEB_CYCLES + 10);
      btn_in = 1'b0; cyc(1);
      btn_in = 1'b1; cyc(w);
      btn_in = 1'b0; cyc(1);
      btn_in = 1'b1; cyc(1);
      btn_in = 1'b0; cyc(DEB_CYCLES + 10);
      expv = (expv + 1) % MODV;
      check("R4 bounced press", expv);
    end

    // R5 reset timing
    if (expv == 0) clean_press();
    rst_in = 1'b1;
    cyc(2);
    check("R5 reset not yet", expv);
    cyc(1);
    check("R5 reset applied", 0);
    expv = 0;
    // R5 presses during reset do nothing
    btn_in = 1'b1; cyc(DEB_CYCLES + 8);
    btn_in = 1'b0; cyc(DEB_CYCLES + 8);
    check("R5 press during reset", 0);

    // R6 held through reset release
    btn_in = 1'b1; cyc(10);
    rst_in = 1'b0; cyc(30);
    check("R6 held at release", 0);
    btn_in = 1'b0; cyc(20);
    check("R6 after release", 0);
    clean_press();
    check("R6 next press", expv);
    check("R7 binary value", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule